// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Translator

This block turns a 16-bit logical address into a 24-bit physical address. The top nibble of the logical address picks one of four segments. The two highest nibble values always form an 8 KB extended window. Two programmable nibble boundaries split the remaining range into root, data and stack. Root maps one-to-one onto the bottom of physical memory. The data, stack and window segments each add their own 12-bit offset, shifted up by 4 KB, to the logical address. This lets each of them start on any 4 KB boundary of the 16 MB space.

Software programs the block through a small byte-wide write port. The port loads the three offsets, the boundary byte, a split-control byte and a program-counter window byte. The split control can flip physical bit 16 and the bank-select MSB for root-segment and data-segment accesses, so that code and data can see different memories under the same logical address. A mode bit limits those flips to data accesses. The program-counter window marks a range of code addresses whose accesses are always treated as data accesses. Each translation is registered and appears one cycle after its address is presented, together with a 2-bit segment code.

Top module: `seg_xlate`

## Requirements
- R1: The segment is chosen from the logical nibble N = log_addr[15:12]. If N >= 0xE the segment is window (seg_id 3). Otherwise, if N >= boundary[7:4] it is stack (seg_id 2). Otherwise, if N >= boundary[3:0] it is data (seg_id 1). Otherwise it is root (seg_id 0). The tests are applied in that order of priority.
- R2: A root access yields the logical address zero-extended to 24 bits, apart from the inversions of R6 to R8.
- R3: A data, stack or window access yields (log_addr + offset*4096) mod 2^24, where offset is that segment's 12-bit offset. Bits [11:0] always equal log_addr[11:0].
- R4: After reset the boundary byte is 0xFF and all offsets, the split control and the PC window byte are zero. The outputs read phys_addr = 0 and seg_id = 0 until the first translation.
- R5: The configuration write addresses are as follows:
  - Data offset: legacy 0, low 1, high 2.
  - Stack offset: legacy 3, low 4, high 5.
  - Window offset: low 6, high 7.
  - Boundary: 8. Split control: 9. PC window: 10.

  A legacy write loads offset[7:0] and clears offset[11:8]. A low write changes only [7:0]. A high write changes only [11:8], taken from data[3:0].
- R6: Split-control bit 0 inverts physical bit 16 for root accesses, and bit 1 inverts physical bit 19 (the bank-select MSB) for root accesses.
- R7: Split-control bit 2 inverts physical bit 16 for data-segment accesses, and bit 3 inverts physical bit 19 for data-segment accesses. Stack and window accesses are never inverted.
- R8: When split-control bit 4 is 1, the inversions of R6 and R7 apply only to data-type accesses. When it is 0, they apply to every access.
- R9: An access is data-type when is_data is 1 or when the PC window hits. The PC window byte holds a compare value in [7:2] and a mode in [1:0]. The window hits under these conditions:
  - Mode 01: pc[15:10] equals byte[7:2].
  - Mode 10: pc[15:11] equals byte[7:3].
  - Mode 11: pc[15:12] equals byte[7:4].
  - Mode 00: never.
- R10: The outputs change exactly one clock edge after the address is sampled. A configuration write first affects addresses sampled at the following edge.
- R11: Writes to configuration addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| log_addr | input | 16 | Logical address to translate |
| is_data | input | 1 | 1 for a data access, 0 for an instruction access |
| pc | input | 16 | Program counter of the access |
| phys_addr | output | 24 | Registered physical address |
| seg_id | output | 2 | Registered segment code (0 root, 1 data, 2 stack, 3 window) |

## Verification
- **Translation timing:** a translation is due one rising edge after its address is presented. The bench drives each address on a falling edge and compares both outputs on the next falling edge, so exactly one register lies between stimulus and sample.
- **Configuration timing:** configuration writes are issued and retired in a cycle of their own, before the next address is driven, so every expected value uses the settled configuration.
- **R10 check:** a dedicated check drives a new address and samples just after the drive but before the edge. It confirms that the old result is still held there, and that the new result appears one edge later.

// File: rtl/seg_xlate_pkg.sv
// Shared types and configuration addresses for the segmented address translator.
package seg_xlate_pkg;

    // Segment code reported with every translation.
    typedef enum logic [1:0] {
        SEG_ROOT  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_WIN   = 2'd3
    } seg_t;

    // Split-control byte, bit 0 at the bottom.
    typedef struct packed {
        logic data_only;      // bit 4: inversions only for data-type accesses
        logic dat_bank_inv;   // bit 3: invert bank MSB in data segment
        logic dat_a16_inv;    // bit 2: invert bit 16 in data segment
        logic root_bank_inv;  // bit 1: invert bank MSB in root segment
        logic root_a16_inv;   // bit 0: invert bit 16 in root segment
    } split_ctl_t;

    localparam int CFG_AW = 4;

    localparam logic [CFG_AW-1:0] CFG_DAT_LEGACY = 4'd0;
    localparam logic [CFG_AW-1:0] CFG_DAT_LO     = 4'd1;
    localparam logic [CFG_AW-1:0] CFG_DAT_HI     = 4'd2;
    localparam logic [CFG_AW-1:0] CFG_STK_LEGACY = 4'd3;
    localparam logic [CFG_AW-1:0] CFG_STK_LO     = 4'd4;
    localparam logic [CFG_AW-1:0] CFG_STK_HI     = 4'd5;
    localparam logic [CFG_AW-1:0] CFG_WIN_LO     = 4'd6;
    localparam logic [CFG_AW-1:0] CFG_WIN_HI     = 4'd7;
    localparam logic [CFG_AW-1:0] CFG_BOUND      = 4'd8;
    localparam logic [CFG_AW-1:0] CFG_SPLIT      = 4'd9;
    localparam logic [CFG_AW-1:0] CFG_PCWIN      = 4'd10;

endpackage

// File: rtl/seg_cfg_regs.sv
// Configuration register file for the translator.
// Holds three offsets, the boundary byte, the split control and the PC window byte.
// Assumes OFF_W > CFG_W, so that each offset has a low byte and a high part.
module seg_cfg_regs
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int CFG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [OFF_W-1:0]  dat_off,
    output logic [OFF_W-1:0]  stk_off,
    output logic [OFF_W-1:0]  win_off,
    output logic [CFG_W-1:0]  bound,
    output split_ctl_t        split_ctl,
    output logic [CFG_W-1:0]  pc_win
);

    localparam int HI_W = OFF_W - CFG_W;
    localparam int CTL_W = $bits(split_ctl_t);

    // Compute the next value of one offset from the legacy, low and high selects.
    function automatic logic [OFF_W-1:0] next_off(
        input logic [OFF_W-1:0] cur,
        input logic             leg,
        input logic             lo,
        input logic             hi,
        input logic [CFG_W-1:0] d
    );
        logic [OFF_W-1:0] n;
        n = cur;
        if (leg) begin
            n = {{HI_W{1'b0}}, d};
        end else if (lo) begin
            n[CFG_W-1:0] = d;
        end else if (hi) begin
            n[OFF_W-1:CFG_W] = d[HI_W-1:0];
        end
        return n;
    endfunction

    logic sel_dleg, sel_dlo, sel_dhi;
    logic sel_sleg, sel_slo, sel_shi;
    logic sel_wlo, sel_whi;

    // Decode the write strobe into per-register selects.
    always_comb begin
        sel_dleg = cfg_we && (cfg_addr == CFG_DAT_LEGACY);
        sel_dlo  = cfg_we && (cfg_addr == CFG_DAT_LO);
        sel_dhi  = cfg_we && (cfg_addr == CFG_DAT_HI);
        sel_sleg = cfg_we && (cfg_addr == CFG_STK_LEGACY);
        sel_slo  = cfg_we && (cfg_addr == CFG_STK_LO);
        sel_shi  = cfg_we && (cfg_addr == CFG_STK_HI);
        sel_wlo  = cfg_we && (cfg_addr == CFG_WIN_LO);
        sel_whi  = cfg_we && (cfg_addr == CFG_WIN_HI);
    end

    // Offset registers: all reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_off <= '0;
            stk_off <= '0;
            win_off <= '0;
        end else begin
            dat_off <= next_off(dat_off, sel_dleg, sel_dlo, sel_dhi, cfg_wdata);
            stk_off <= next_off(stk_off, sel_sleg, sel_slo, sel_shi, cfg_wdata);
            win_off <= next_off(win_off, 1'b0, sel_wlo, sel_whi, cfg_wdata);
        end
    end

    // Boundary, split control and PC window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound     <= '1;
            split_ctl <= '0;
            pc_win    <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_BOUND) bound <= cfg_wdata;
            if (cfg_addr == CFG_SPLIT) split_ctl <= split_ctl_t'(cfg_wdata[CTL_W-1:0]);
            if (cfg_addr == CFG_PCWIN) pc_win <= cfg_wdata;
        end
    end

endmodule

// File: rtl/seg_classify.sv
// Segment classifier.
// Compares the logical top nibble against the fixed window start and two programmable boundaries.
// Assumes the two highest nibble values always form the window, whatever the boundaries are.
module seg_classify
    import seg_xlate_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] nib,
    input  logic [NIB_W-1:0] bnd_data,
    input  logic [NIB_W-1:0] bnd_stack,
    output seg_t             seg
);

    localparam logic [NIB_W-1:0] WIN_START = NIB_W'((1 << NIB_W) - 2);

    // Priority compare: window, then stack, then data, else root.
    always_comb begin
        if (nib >= WIN_START)      seg = SEG_WIN;
        else if (nib >= bnd_stack) seg = SEG_STACK;
        else if (nib >= bnd_data)  seg = SEG_DATA;
        else                       seg = SEG_ROOT;
    end

endmodule

// File: rtl/seg_pc_window.sv
// PC window compare.
// Flags a hit when the top bits of the PC match the compare field.
// The compare width is chosen by the 2-bit mode in the low bits of the window byte; mode 0 disables it.
module seg_pc_window #(
    parameter int LOG_W = 16,
    parameter int CFG_W = 8
) (
    input  logic [LOG_W-1:0] pc,
    input  logic [CFG_W-1:0] pc_win,
    output logic             hit
);

    localparam int CMP_W  = CFG_W - 2;
    localparam int NMODES = 3;

    logic [NMODES-1:0] match;

    // One comparator per width; mode k uses CMP_W-(k-1) bits.
    genvar g;
    generate
        for (g = 0; g < NMODES; g++) begin : g_cmp
            localparam int W = CMP_W - g;
            assign match[g] = (pc[LOG_W-1 -: W] == pc_win[CFG_W-1 -: W]);
        end
    endgenerate

    // Select the comparator named by the mode field.
    always_comb begin
        case (pc_win[1:0])
            2'b01:   hit = match[0];
            2'b10:   hit = match[1];
            2'b11:   hit = match[2];
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_map.sv
// Physical address builder.
// Adds the selected offset to the page number and applies the split-space inversions.
// Only the page part is added: the low PAGE_W bits pass straight through.
module seg_map
    import seg_xlate_pkg::*;
#(
    parameter int LOG_W    = 16,
    parameter int PHYS_W   = 24,
    parameter int PAGE_W   = 12,
    parameter int BANK_MSB = 19
) (
    input  logic [LOG_W-1:0]         log_addr,
    input  seg_t                     seg,
    input  logic [PHYS_W-PAGE_W-1:0] dat_off,
    input  logic [PHYS_W-PAGE_W-1:0] stk_off,
    input  logic [PHYS_W-PAGE_W-1:0] win_off,
    input  split_ctl_t               split_ctl,
    input  logic                     eff_data,
    output logic [PHYS_W-1:0]        phys
);

    localparam int OFF_W = PHYS_W - PAGE_W;
    localparam int NIB_W = LOG_W - PAGE_W;
    localparam int A16   = LOG_W;

    logic [OFF_W-1:0]  off_sel;
    logic [OFF_W-1:0]  page;
    logic              inv_ok;
    logic              flip_a16;
    logic              flip_bank;
    logic [PHYS_W-1:0] flip_mask;

    // Pick the offset for the segment; root adds nothing.
    always_comb begin
        case (seg)
            SEG_DATA:  off_sel = dat_off;
            SEG_STACK: off_sel = stk_off;
            SEG_WIN:   off_sel = win_off;
            default:   off_sel = '0;
        endcase
    end

    // Page add, wrapping in OFF_W bits (same as mod 2^PHYS_W on the whole address).
    always_comb begin
        page = OFF_W'(log_addr[LOG_W-1 -: NIB_W]) + off_sel;
    end

    // Decide which inversions apply to this access.
    always_comb begin
        inv_ok    = !split_ctl.data_only || eff_data;
        flip_a16  = 1'b0;
        flip_bank = 1'b0;
        if (inv_ok && seg == SEG_ROOT) begin
            flip_a16  = split_ctl.root_a16_inv;
            flip_bank = split_ctl.root_bank_inv;
        end else if (inv_ok && seg == SEG_DATA) begin
            flip_a16  = split_ctl.dat_a16_inv;
            flip_bank = split_ctl.dat_bank_inv;
        end
        flip_mask = '0;
        flip_mask[A16]      = flip_a16;
        flip_mask[BANK_MSB] = flip_bank;
    end

    // Assemble the physical address.
    always_comb begin
        phys = {page, log_addr[PAGE_W-1:0]} ^ flip_mask;
    end

endmodule

// File: rtl/seg_xlate.sv
// Segmented logical-to-physical address translator (top).
// Classifies each logical address into root, data, stack or window, and adds the segment's offset.
// Applies the optional split-space inversions and registers the result with one cycle of latency.
// Assumes a synchronous active-low reset and configuration writes on a byte-wide port.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int LOG_W    = 16,
    parameter int PHYS_W   = 24,
    parameter int PAGE_W   = 12,
    parameter int CFG_W    = 8,
    parameter int BANK_MSB = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [LOG_W-1:0]  log_addr,
    input  logic              is_data,
    input  logic [LOG_W-1:0]  pc,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [1:0]        seg_id
);

    localparam int OFF_W = PHYS_W - PAGE_W;
    localparam int NIB_W = LOG_W - PAGE_W;

    logic [OFF_W-1:0]  dat_off, stk_off, win_off;
    logic [CFG_W-1:0]  bound, pc_win;
    split_ctl_t        split_ctl;
    seg_t              seg_c;
    logic              pc_hit;
    logic              eff_data;
    logic [PHYS_W-1:0] phys_c;

    seg_cfg_regs #(.OFF_W(OFF_W), .CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .dat_off   (dat_off),
        .stk_off   (stk_off),
        .win_off   (win_off),
        .bound     (bound),
        .split_ctl (split_ctl),
        .pc_win    (pc_win)
    );

    seg_classify #(.NIB_W(NIB_W)) u_cls (
        .nib       (log_addr[LOG_W-1 -: NIB_W]),
        .bnd_data  (bound[NIB_W-1:0]),
        .bnd_stack (bound[CFG_W-1 -: NIB_W]),
        .seg       (seg_c)
    );

    seg_pc_window #(.LOG_W(LOG_W), .CFG_W(CFG_W)) u_pcw (
        .pc     (pc),
        .pc_win (pc_win),
        .hit    (pc_hit)
    );

    // An access counts as data-type if flagged so or if the PC window hits.
    always_comb begin
        eff_data = is_data || pc_hit;
    end

    seg_map #(
        .LOG_W(LOG_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .BANK_MSB(BANK_MSB)
    ) u_map (
        .log_addr  (log_addr),
        .seg       (seg_c),
        .dat_off   (dat_off),
        .stk_off   (stk_off),
        .win_off   (win_off),
        .split_ctl (split_ctl),
        .eff_data  (eff_data),
        .phys      (phys_c)
    );

    // Output register: translation appears one edge after sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            seg_id    <= SEG_ROOT;
        end else begin
            phys_addr <= phys_c;
            seg_id    <= seg_c;
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
// Property checker for the translator; attached to every seg_xlate instance by the bind below.
module seg_xlate_chk
    import seg_xlate_pkg::*;
#(
    parameter int LOG_W  = 16,
    parameter int PHYS_W = 24,
    parameter int PAGE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LOG_W-1:0]  log_addr,
    input logic [PHYS_W-1:0] phys_addr,
    input logic [1:0]        seg_id
);

    localparam int NIB_W = LOG_W - PAGE_W;
    localparam logic [NIB_W-1:0] WIN_START = NIB_W'((1 << NIB_W) - 2);

    // Set once the previous edge was out of reset, so $past refers to a real translation.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_win_only_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && seg_id == SEG_WIN) |-> ($past(log_addr[LOG_W-1 -: NIB_W]) >= WIN_START));

    assert_top_is_win_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(log_addr[LOG_W-1 -: NIB_W]) >= WIN_START) |-> (seg_id == SEG_WIN));

    assert_root_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && seg_id == SEG_ROOT) |-> (phys_addr[LOG_W-1:0] == $past(log_addr)));

    assert_page_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (phys_addr[PAGE_W-1:0] == $past(log_addr[PAGE_W-1:0])));

    assert_reset_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phys_addr == '0 && seg_id == SEG_ROOT));

endmodule

bind seg_xlate seg_xlate_chk #(.LOG_W(LOG_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_addr  (log_addr),
    .phys_addr (phys_addr),
    .seg_id    (seg_id)
);

// File: tb/seg_xlate_bench.sv
// Sweep bench for the translator; expected values come from an arithmetic model of the requirements.
module seg_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [15:0] log_addr;
    logic        is_data;
    logic [15:0] pc;
    logic [23:0] phys_addr;
    logic [1:0]  seg_id;

    int n_chk = 0;
    int n_err = 0;

    // Shadow configuration held by the bench.
    logic [11:0] m_doff, m_soff, m_woff;
    logic [7:0]  m_bnd, m_ctl, m_pcw;

    always #2 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .log_addr(log_addr), .is_data(is_data), .pc(pc),
        .phys_addr(phys_addr), .seg_id(seg_id)
    );

    task automatic check(input logic [23:0] ep, input logic [1:0] es, input string req);
        n_chk++;
        if (phys_addr !== ep || seg_id !== es) begin
            n_err++;
            $display("FAIL %s: phys=%06h seg=%0d expected phys=%06h seg=%0d (log=%04h isd=%0b pc=%04h)",
                     req, phys_addr, seg_id, ep, es, log_addr, is_data, pc);
        end
    endtask

    // Model of R1, R2, R3 and R6-R9: returns {seg, phys}.
    function automatic logic [25:0] model(input logic [15:0] la, input logic isd, input logic [15:0] p);
        logic [3:0]  nib;
        logic [1:0]  s;
        logic [11:0] off;
        logic [23:0] ph;
        logic        hit, effd, ok;
        nib = la[15:12];
        if (nib >= 4'hE)            s = 2'd3;
        else if (nib >= m_bnd[7:4]) s = 2'd2;
        else if (nib >= m_bnd[3:0]) s = 2'd1;
        else                        s = 2'd0;
        off = (s == 2'd1) ? m_doff : (s == 2'd2) ? m_soff : (s == 2'd3) ? m_woff : 12'h000;
        ph = {8'h00, la} + {off, 12'h000};
        case (m_pcw[1:0])
            2'b01:   hit = (p[15:10] == m_pcw[7:2]);
            2'b10:   hit = (p[15:11] == m_pcw[7:3]);
            2'b11:   hit = (p[15:12] == m_pcw[7:4]);
            default: hit = 1'b0;
        endcase
        effd = isd | hit;
        ok = !m_ctl[4] || effd;
        if (ok && s == 2'd0) begin
            if (m_ctl[0]) ph[16] = ~ph[16];
            if (m_ctl[1]) ph[19] = ~ph[19];
        end
        if (ok && s == 2'd1) begin
            if (m_ctl[2]) ph[16] = ~ph[16];
            if (m_ctl[3]) ph[19] = ~ph[19];
        end
        return {s, ph};
    endfunction

    // Configuration write in a cycle of its own; the shadow follows R5 and R11.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            4'd0:  m_doff = {4'h0, d};
            4'd1:  m_doff[7:0] = d;
            4'd2:  m_doff[11:8] = d[3:0];
            4'd3:  m_soff = {4'h0, d};
            4'd4:  m_soff[7:0] = d;
            4'd5:  m_soff[11:8] = d[3:0];
            4'd6:  m_woff[7:0] = d;
            4'd7:  m_woff[11:8] = d[3:0];
            4'd8:  m_bnd = d;
            4'd9:  m_ctl = {3'b000, d[4:0]};
            4'd10: m_pcw = d;
            default: ;
        endcase
    endtask

    // Drive one translation and check it one edge later.
    task automatic xl(input logic [15:0] la, input logic isd, input logic [15:0] p, input string req);
        logic [25:0] e;
        @(negedge clk);
        log_addr = la; is_data = isd; pc = p;
        e = model(la, isd, p);
        @(negedge clk);
        check(e[23:0], e[25:24], req);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R10: watchdog expired, actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [25:0] ea;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        log_addr = 16'h0000; is_data = 1'b0; pc = 16'h0000;
        m_doff = '0; m_soff = '0; m_woff = '0; m_bnd = 8'hFF; m_ctl = '0; m_pcw = '0;
        repeat (3) @(negedge clk);
        log_addr = 16'hF123;
        @(negedge clk);
        rst_n = 1'b1;
        // R4: outputs hold the reset value right after reset.
        check(24'h000000, 2'd0, "R4 reset outputs");

        // R4 / R1: default boundaries put 0x0-0xD in root and 0xE-0xF in the window, with zero offset.
        for (int n = 0; n < 16; n++) xl({n[3:0], 12'hA5C}, 1'b0, 16'h0, "R4 R1 default map");

        // R5: full offsets through the low/high registers; R3 wrap via window 0xFFF.
        wr(4'd1, 8'h23); wr(4'd2, 8'hF1);
        wr(4'd4, 8'hBC); wr(4'd5, 8'h0A);
        wr(4'd6, 8'hFF); wr(4'd7, 8'h0F);

        // R1 R2 R3: every boundary pair against every nibble.
        for (int db = 0; db < 16; db++) begin
            for (int sb = 0; sb < 16; sb++) begin
                wr(4'd8, {sb[3:0], db[3:0]});
                for (int n = 0; n < 16; n++)
                    xl({n[3:0], 12'h3E7}, 1'b1, 16'h0, "R1 R2 R3 boundary sweep");
            end
        end

        // R5: a legacy write clears the high bits; a high write leaves the low byte alone.
        wr(4'd8, 8'h84);
        wr(4'd2, 8'h0F); wr(4'd0, 8'h5A);
        xl(16'h4321, 1'b1, 16'h0, "R5 legacy data clears high");
        wr(4'd2, 8'h07);
        xl(16'h5FFF, 1'b1, 16'h0, "R5 high write keeps low");
        wr(4'd5, 8'h03); wr(4'd3, 8'hC3);
        xl(16'h9000, 1'b0, 16'h0, "R5 legacy stack clears high");
        wr(4'd4, 8'h11);
        xl(16'hD0F0, 1'b0, 16'h0, "R5 low write keeps high");

        // R6 R7 R8: every split-control value, both access types, every nibble.
        for (int c = 0; c < 32; c++) begin
            wr(4'd9, c[7:0]);
            for (int d = 0; d < 2; d++)
                for (int n = 0; n < 16; n++)
                    xl({n[3:0], 12'h0B4}, d[0], 16'h0, "R6 R7 R8 inversion sweep");
        end

        // R9: the PC window forces data-type inversions under data-only mode.
        wr(4'd9, 8'h13);
        for (int m = 0; m < 4; m++) begin
            wr(4'd10, {6'b101101, m[1:0]});
            for (int k = 0; k < 64; k++)
                xl(16'h1234, 1'b0, {k[5:0], 10'h155}, "R9 pc window modes");
        end

        // R11: writes to unused addresses leave every register as it was.
        for (int a = 11; a < 16; a++) wr(a[3:0], 8'hFF);
        for (int n = 0; n < 16; n++) xl({n[3:0], 12'h777}, 1'b1, 16'h2C00, "R11 unused addresses ignored");

        // R10: a new address does not show until the following edge.
        xl(16'h0100, 1'b0, 16'h0, "R10 first address");
        ea = model(16'h0100, 1'b0, 16'h0);
        @(negedge clk);
        log_addr = 16'hE200;
        #1;
        check(ea[23:0], ea[25:24], "R10 old result held before edge");
        ea = model(16'hE200, 1'b0, 16'h0);
        @(negedge clk);
        check(ea[23:0], ea[25:24], "R10 new result after one edge");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule